// File: doc/BRIEF.md
# Multi-Region MMIO Address Decoder

This block sits behind a 128 KB memory-mapped window and steers each access to its target. It takes a 17-bit byte offset, a read/write flag and an access size. The offset lands in one of three regions: peripheral device registers, DMA channel registers or the interrupt register group. In the device region the block picks one of 16 slots from the offset. It then forms the register index in the shape that each slot's target expects. A serial slot also offers a compatibility view that remaps low addresses through a computed table.

All outputs are registered and appear one clock after the request is sampled. There is one select line per device target, one per I/O-bus device, one per DMA channel and one for the interrupt group. Alongside them come the derived index, the DMA register offset and the interrupt register offset. Reads of slot 9 return a byte from a built-in 8-byte identification ROM, which is set by a parameter. Some accesses have no target: a slot whose target is absent, a DMA channel that is not implemented, or a write to the ROM. These assert no select, return zero and raise an unmapped flag.

Top module: `mmio_region_decode`

## Requirements
- R1: Bit 16 of the offset, when set, selects the device region. Otherwise bit 15 selects the DMA region. Otherwise the access goes to the interrupt region. Exactly one select or the unmapped flag is high in the cycle after a valid request, and all selects are low in the cycle after no request. The device slot number is offset[15:12].
- R2: Slots 0, 3, 5 and 8 assert dev_sel bits 0, 2, 4 and 6, with tgt_index = offset[7:4] zero-extended.
- R3: Slot 1 asserts dev_sel[1] with tgt_index = offset[8:4].
- R4: Slot 2 asserts dev_sel[2]. When offset[7:0] < 16, tgt_index = {k[0], k[3:1]} where k = offset[4:1]. Otherwise tgt_index = offset[7:4], the same as slot 3.
- R5: Slots 6 and 7 both assert dev_sel[5] with tgt_index = offset[12:9].
- R6: A read of slot 9 asserts dev_sel[7], gives tgt_index = offset[6:4], and returns rd_data = byte n of ID_ROM (bits 8n+7:8n) with n = offset[6:4]. A write to slot 9 is unmapped.
- R7: Slots 10 to 15 map to I/O-bus device n = slot - 10, with iob_sel[n] high and tgt_index = offset[8:4]. A device whose bit in IOB_PRESENT is 0 is unmapped.
- R8: Slot 4 asserts dev_sel[3] with tgt_index = offset[7:0]. xfer_size repeats the request's size for every valid request.
- R9: In the DMA region, channel c = offset[11:8] asserts dma_sel[c] with dma_reg = offset[7:0] when DMA_IMPL[c] is 1. Otherwise the access is unmapped.
- R10: In the interrupt region, int_sel is high and int_reg = offset[14:0].
- R11: An unmapped access asserts no select and returns rd_data = 0. rd_data is zero for every access that is not a slot-9 read.
- R12: While reset is held, and in the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 17 | Byte offset inside the window |
| req_size | input | 2 | Access size code |
| dev_sel | output | 8 | Device target selects (bit 7 = ROM) |
| iob_sel | output | 6 | I/O-bus device selects |
| dma_sel | output | 16 | DMA channel selects |
| int_sel | output | 1 | Interrupt group select |
| tgt_index | output | 8 | Register index for the selected device |
| dma_reg | output | 8 | DMA channel register offset |
| int_reg | output | 15 | Interrupt register offset |
| xfer_size | output | 2 | Access size passed to the target |
| rd_data | output | 8 | ROM read data, zero otherwise |
| unmapped | output | 1 | Access had no target |

## Verification
The bench uses the default parameters. With these, only DMA channels 0, 1, 8 and 11 are implemented, and only I/O-bus devices 2, 3 and 5 are present. Random offsets therefore reach both the implemented and the unimplemented DMA channels, and both the present and the absent I/O-bus devices, along with every device slot. The default ROM pattern has a distinct non-zero value in every byte, so a wrong ROM byte selection shows up in rd_data. Directed cases cover the compatibility boundary at low byte 15 and 16, the shared controller slots 6 and 7, and ROM writes.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  localparam int OFS_W = 17;
  localparam int N_DEV = 8;
  localparam int N_IOB = 6;
  localparam int N_DMA = 16;
  localparam int IDX_W = 8;

  // compatibility view of the serial slot: rotate the 4-bit word index
  function automatic logic [3:0] serial_compat(input logic [3:0] k);
    return {k[0], k[3:1]};
  endfunction

  function automatic logic [7:0] rom_byte(input logic [63:0] rom, input logic [2:0] n);
    return rom[{n, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/mmio_slot_decode.sv
module mmio_slot_decode
  import mmio_dec_pkg::*;
#(
  parameter logic [N_IOB-1:0] IOB_PRESENT = 6'b101100
) (
  input  logic [15:0]      ofs,
  input  logic             is_write,
  output logic [N_DEV-1:0] dev_sel,
  output logic [N_IOB-1:0] iob_sel,
  output logic [IDX_W-1:0] index,
  output logic             miss
);
  logic [3:0] slot;
  assign slot = ofs[15:12];

  always_comb begin
    dev_sel = '0;
    iob_sel = '0;
    index   = '0;
    miss    = 1'b0;
    case (slot)
      4'd0: begin dev_sel[0] = 1'b1; index = {4'b0, ofs[7:4]}; end
      4'd1: begin dev_sel[1] = 1'b1; index = {3'b0, ofs[8:4]}; end
      4'd2: begin
        dev_sel[2] = 1'b1;
        if (ofs[7:0] < 8'd16) index = {4'b0, serial_compat(ofs[4:1])};
        else                  index = {4'b0, ofs[7:4]};
      end
      4'd3: begin dev_sel[2] = 1'b1; index = {4'b0, ofs[7:4]}; end
      4'd4: begin dev_sel[3] = 1'b1; index = ofs[7:0]; end
      4'd5: begin dev_sel[4] = 1'b1; index = {4'b0, ofs[7:4]}; end
      4'd6, 4'd7: begin dev_sel[5] = 1'b1; index = {4'b0, ofs[12:9]}; end
      4'd8: begin dev_sel[6] = 1'b1; index = {4'b0, ofs[7:4]}; end
      4'd9: begin
        if (is_write) miss = 1'b1;
        else begin dev_sel[7] = 1'b1; index = {5'b0, ofs[6:4]}; end
      end
      default: begin
        miss = 1'b1;
        for (int i = 0; i < N_IOB; i++) begin
          if (slot == 4'(10 + i) && IOB_PRESENT[i]) begin
            miss       = 1'b0;
            iob_sel[i] = 1'b1;
            index      = {3'b0, ofs[8:4]};
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/mmio_dma_decode.sv
module mmio_dma_decode
  import mmio_dec_pkg::*;
#(
  parameter logic [N_DMA-1:0] DMA_IMPL = 16'h0903
) (
  input  logic [11:8]      ofs_chan,
  output logic [N_DMA-1:0] sel,
  output logic             miss
);
  for (genvar ch = 0; ch < N_DMA; ch++) begin : g_chan
    assign sel[ch] = DMA_IMPL[ch] && (ofs_chan == 4'(ch));
  end
  assign miss = ~|sel;
endmodule

// File: rtl/mmio_region_decode.sv
module mmio_region_decode
  import mmio_dec_pkg::*;
#(
  parameter logic [63:0]      ID_ROM      = 64'h5AC3960FE1782DB4,
  parameter logic [N_DMA-1:0] DMA_IMPL    = 16'h0903,
  parameter logic [N_IOB-1:0] IOB_PRESENT = 6'b101100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  output logic [N_DEV-1:0] dev_sel,
  output logic [N_IOB-1:0] iob_sel,
  output logic [N_DMA-1:0] dma_sel,
  output logic             int_sel,
  output logic [IDX_W-1:0] tgt_index,
  output logic [7:0]       dma_reg,
  output logic [14:0]      int_reg,
  output logic [1:0]       xfer_size,
  output logic [7:0]       rd_data,
  output logic             unmapped
);
  // region decision, bit 16 has priority over bit 15
  logic in_dev, in_dma, in_int;
  assign in_dev = req_valid &  req_offset[16];
  assign in_dma = req_valid & ~req_offset[16] &  req_offset[15];
  assign in_int = req_valid & ~req_offset[16] & ~req_offset[15];

  logic [N_DEV-1:0] s_dev_sel;
  logic [N_IOB-1:0] s_iob_sel;
  logic [IDX_W-1:0] s_index;
  logic             s_miss;
  logic [N_DMA-1:0] d_sel;
  logic             d_miss;

  mmio_slot_decode #(.IOB_PRESENT(IOB_PRESENT)) u_slot (
    .ofs(req_offset[15:0]), .is_write(req_write),
    .dev_sel(s_dev_sel), .iob_sel(s_iob_sel), .index(s_index), .miss(s_miss)
  );

  mmio_dma_decode #(.DMA_IMPL(DMA_IMPL)) u_dma (
    .ofs_chan(req_offset[11:8]), .sel(d_sel), .miss(d_miss)
  );

  logic rom_read;
  assign rom_read = in_dev & s_dev_sel[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_sel   <= '0;
      iob_sel   <= '0;
      dma_sel   <= '0;
      int_sel   <= 1'b0;
      tgt_index <= '0;
      dma_reg   <= '0;
      int_reg   <= '0;
      xfer_size <= '0;
      rd_data   <= '0;
      unmapped  <= 1'b0;
    end else begin
      dev_sel   <= in_dev ? s_dev_sel : '0;
      iob_sel   <= in_dev ? s_iob_sel : '0;
      dma_sel   <= in_dma ? d_sel : '0;
      int_sel   <= in_int;
      tgt_index <= in_dev ? s_index : '0;
      dma_reg   <= in_dma ? req_offset[7:0] : '0;
      int_reg   <= in_int ? req_offset[14:0] : '0;
      xfer_size <= req_valid ? req_size : '0;
      rd_data   <= rom_read ? rom_byte(ID_ROM, req_offset[6:4]) : '0;
      unmapped  <= (in_dev & s_miss) | (in_dma & d_miss);
    end
  end

  // assertions
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_sel, iob_sel, dma_sel, int_sel, unmapped}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (dev_sel == '0 && iob_sel == '0 && dma_sel == '0 && !int_sel && !unmapped));

  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (rd_data == 8'h00));

  p_rom_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != 8'h00) |-> dev_sel[7]);

  p_int_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_offset[16] && !req_offset[15]) |=> (int_sel && int_reg == $past(req_offset[14:0])));

  p_dma_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_offset[16] && req_offset[15]) |=> ((dma_sel != '0 || unmapped) && dma_reg == $past(req_offset[7:0])));
endmodule

// File: tb/mmio_region_decode_tb.sv
module mmio_region_decode_tb;
  localparam logic [63:0] ROM  = 64'h5AC3960FE1782DB4;
  localparam logic [15:0] DMAM = 16'h0903;
  localparam logic [5:0]  IOBM = 6'b101100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [7:0]  dev_sel;
  logic [5:0]  iob_sel;
  logic [15:0] dma_sel;
  logic        int_sel;
  logic [7:0]  tgt_index;
  logic [7:0]  dma_reg;
  logic [14:0] int_reg;
  logic [1:0]  xfer_size;
  logic [7:0]  rd_data;
  logic        unmapped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmio_region_decode u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .dev_sel(dev_sel), .iob_sel(iob_sel),
    .dma_sel(dma_sel), .int_sel(int_sel), .tgt_index(tgt_index), .dma_reg(dma_reg),
    .int_reg(int_reg), .xfer_size(xfer_size), .rd_data(rd_data), .unmapped(unmapped)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [16:0] o, input bit wr);
    int s;
    s = (o >> 12) & 15;
    if (!o[16]) return o[15] ? "R9" : "R10";
    case (s)
      0, 3, 5, 8: return "R2";
      1: return "R3";
      2: return "R4";
      4: return "R8";
      6, 7: return "R5";
      9: return wr ? "R11" : "R6";
      default: return "R7";
    endcase
  endfunction

  // apply one request and compare the registered outputs with a reference
  task automatic access(input logic [16:0] o, input bit wr, input logic [1:0] sz);
    logic [7:0] e_dev; logic [5:0] e_iob; logic [15:0] e_dma;
    logic e_int, e_un; logic [7:0] e_idx, e_dreg, e_rd; logic [14:0] e_ireg;
    int s, k, c, n;
    string t;
    e_dev = 0; e_iob = 0; e_dma = 0; e_int = 0; e_un = 0;
    e_idx = 0; e_dreg = 0; e_rd = 0; e_ireg = 0;
    s = (o >> 12) & 15;
    if (o[16]) begin
      case (s)
        0: begin e_dev = 8'h01; e_idx = (o >> 4) & 15; end
        1: begin e_dev = 8'h02; e_idx = (o >> 4) & 31; end
        2: begin
          e_dev = 8'h04;
          if ((o & 255) < 16) begin
            k = (o >> 1) & 15;
            e_idx = ((k & 1) << 3) | (k >> 1);
          end else e_idx = (o >> 4) & 15;
        end
        3: begin e_dev = 8'h04; e_idx = (o >> 4) & 15; end
        4: begin e_dev = 8'h08; e_idx = o & 255; end
        5: begin e_dev = 8'h10; e_idx = (o >> 4) & 15; end
        6, 7: begin e_dev = 8'h20; e_idx = (o >> 9) & 15; end
        8: begin e_dev = 8'h40; e_idx = (o >> 4) & 15; end
        9: begin
          if (wr) e_un = 1;
          else begin
            n = (o >> 4) & 7;
            e_dev = 8'h80; e_idx = n; e_rd = (ROM >> (8 * n)) & 64'hFF;
          end
        end
        default: begin
          n = s - 10;
          if (IOBM[n]) begin e_iob = 6'(1 << n); e_idx = (o >> 4) & 31; end
          else e_un = 1;
        end
      endcase
    end else if (o[15]) begin
      c = (o >> 8) & 15;
      e_dreg = o & 255;
      if (DMAM[c]) e_dma = 16'(1 << c); else e_un = 1;
    end else begin
      e_int = 1; e_ireg = o & 17'h7FFF;
    end
    t = tag_of(o, wr);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = o; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    chk(dev_sel == e_dev, t, "dev_sel", 32'(dev_sel), 32'(e_dev));
    chk(iob_sel == e_iob, t, "iob_sel", 32'(iob_sel), 32'(e_iob));
    chk(dma_sel == e_dma, t, "dma_sel", 32'(dma_sel), 32'(e_dma));
    chk(int_sel == e_int, t, "int_sel", 32'(int_sel), 32'(e_int));
    chk(tgt_index == e_idx, t, "tgt_index", 32'(tgt_index), 32'(e_idx));
    chk(dma_reg == e_dreg, t, "dma_reg", 32'(dma_reg), 32'(e_dreg));
    chk(int_reg == e_ireg, t, "int_reg", 32'(int_reg), 32'(e_ireg));
    chk(rd_data == e_rd, e_un ? "R11" : t, "rd_data", 32'(rd_data), 32'(e_rd));
    chk(unmapped == e_un, e_un ? "R11" : t, "unmapped", 32'(unmapped), 32'(e_un));
    chk(xfer_size == sz, "R8", "xfer_size", 32'(xfer_size), 32'(sz));
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(dev_sel == 0 && iob_sel == 0 && dma_sel == 0 && !int_sel && !unmapped,
        "R1", "idle selects", {dev_sel, iob_sel, dma_sel, int_sel, unmapped}, 0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    // R12 reset state
    repeat (3) @(negedge clk);
    chk({dev_sel, iob_sel, dma_sel, int_sel, tgt_index, rd_data, unmapped} == 0,
        "R12", "outputs in reset", 32'(tgt_index), 0);
    rst_n = 1;
    @(negedge clk);
    chk({dev_sel, iob_sel, dma_sel, int_sel, int_reg, rd_data, unmapped} == 0,
        "R12", "outputs after reset", 32'(int_reg), 0);
    // directed corners
    access(17'h1_000F, 0, 2'd0);   // R4 compat, low byte 15
    access(17'h1_0010, 0, 2'd0);   // R4 native, low byte 16
    access(17'h1_000A, 1, 2'd1);   // R4 compat
    access(17'h1_30F0, 0, 2'd0);   // R2 slot 3
    access(17'h1_41A7, 1, 2'd2);   // R8 audio
    access(17'h1_1150, 0, 2'd0);   // R3 5-bit index
    access(17'h1_7E00, 0, 2'd0);   // R5 slot 7
    access(17'h1_6200, 1, 2'd0);   // R5 slot 6
    for (int i = 0; i < 8; i++) access(17'h1_9000 | 17'(i << 4), 0, 2'd0); // R6 ROM bytes
    access(17'h1_9030, 1, 2'd0);   // R6/R11 ROM write
    for (int i = 10; i < 16; i++) access(17'h1_0000 | 17'(i << 12) | 17'h1F0, 0, 2'd3); // R7
    for (int i = 0; i < 16; i++) access(17'h0_8000 | 17'(i << 8) | 17'h5C, 0, 2'd0);    // R9
    access(17'h1_8000, 0, 2'd0);   // R1 bit 16 beats bit 15
    access(17'h0_7FFF, 0, 2'd0);   // R10
    access(17'h0_0000, 1, 2'd0);   // R10
    idle_check();
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [16:0] o;
      o = 17'($urandom);
      if ($urandom % 4 == 0) o[7:4] = 4'h0;
      access(o, 1'($urandom), 2'($urandom));
      if (i % 50 == 0) idle_check();
    end
    idle_check();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule